// File: doc/BRIEF.md
# Timer Channel Polarity and Enable Stage

This block sits between one timer channel's internal logic and its pins. In output mode it takes the channel's reference waveform and forms two pin signals: a main output and a complementary output. Each has its own polarity bit and its own enable bit. In input mode it takes an already filtered input signal, applies an optional inversion and turns the selected edges into single-cycle capture or trigger events.

Four control bits sit behind a single write strobe, and the current value can always be read back. A two-bit protection level can freeze the two polarity bits. The two enable bits stay writable at every protection level. The counter, compare and capture registers, dead-time insertion, break handling and input filtering are outside this block.

Top module: `tmr_chan_pol`

## Requirements
- R1: After reset, all four control bits read 0, and `out_main`, `out_comp` and `evt_pulse` are 0.
- R2: In output mode (`mode_in`=0) with the channel enable bit (bit 0) set, `out_main` equals `ref_in` XOR the main polarity bit (bit 1). A polarity of 0 gives active high and 1 gives active low.
- R3: In output mode with the complementary enable bit (bit 2) set, `out_comp` equals NOT `ref_in` XOR the complementary polarity bit (bit 3).
- R4: An output whose enable bit is 0 is driven to 0 whatever its polarity bit holds. In input mode both outputs are 0.
- R5: In input mode, the pair {bit 3, bit 1} selects the active edges of `sig_in`: 00 selects rising edges with no inversion, 01 selects falling edges with the input inverted, and 11 selects both edges with no inversion. The event pulse is one clock wide. It is high during the cycle that follows the first clock edge at which the new input level is sampled.
- R6: The reserved pair {bit 3, bit 1} = 10 behaves exactly like 00: rising edges only, no inversion, and no other events.
- R7: `evt_pulse` stays 0 unless `mode_in`=1 and the channel enable bit is 1.
- R8: While `prot_lvl` is 2'b10 or 2'b11, a write leaves bits 1 and 3 unchanged, and `rd_data` keeps showing the held values.
- R9: A write (`wr_en`=1) updates bits 0 and 2 at every protection level. It also updates bits 1 and 3 when `prot_lvl` is 2'b00 or 2'b01. `rd_data` shows all four bits one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_in | input | 1 | 0 = output mode, 1 = input mode |
| ref_in | input | 1 | Internal reference waveform (output mode) |
| sig_in | input | 1 | Filtered input signal (input mode) |
| prot_lvl | input | 2 | Protection level; 2'b1x locks the polarity bits |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 4 | Write word: [0] channel enable, [1] main polarity, [2] complementary enable, [3] complementary polarity |
| rd_data | output | 4 | Current control bits, same layout as the write word |
| out_main | output | 1 | Main output |
| out_comp | output | 1 | Complementary output |
| evt_pulse | output | 1 | Capture or trigger event, one clock wide |

## Verification
A control write and an input edge can land in the same cycle. The case that matters is a write that changes the polarity pair, or one blocked by the lock, arriving while `sig_in` moves. The edge sampled at that clock must be conditioned with the polarity held before the write, and the pulse one cycle later must be judged with the new selection. The bench provokes this case by mixing random writes, protection levels and input toggles in input mode. A behavioural model updated on every clock supplies the expected output, and every output is compared against it on every cycle.

// File: rtl/tmr_chan_pol.sv
module tmr_chan_pol (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_in,
  input  logic       ref_in,
  input  logic       sig_in,
  input  logic [1:0] prot_lvl,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  output logic       out_main,
  output logic       out_comp,
  output logic       evt_pulse
);
  logic ch_en, pol_m, cmp_en, pol_c;
  logic locked, inv_sel, both_sel, cond;
  logic s_now, s_old, rise, any_edge;

  assign locked = prot_lvl[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_en  <= 1'b0;
      pol_m  <= 1'b0;
      cmp_en <= 1'b0;
      pol_c  <= 1'b0;
    end else if (wr_en) begin
      ch_en  <= wr_data[0];
      cmp_en <= wr_data[2];
      if (!locked) begin
        pol_m <= wr_data[1];
        pol_c <= wr_data[3];
      end
    end
  end

  assign rd_data = {pol_c, cmp_en, pol_m, ch_en};

  assign out_main = ~mode_in & ch_en  & (ref_in ^ pol_m);
  assign out_comp = ~mode_in & cmp_en & (~ref_in ^ pol_c);

  // reserved pair 10 falls through to plain rising edge
  assign inv_sel  = pol_m & ~pol_c;
  assign both_sel = pol_m & pol_c;
  assign cond     = sig_in ^ inv_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_now <= 1'b0;
      s_old <= 1'b0;
    end else begin
      s_now <= cond;
      s_old <= s_now;
    end
  end

  assign rise      = s_now & ~s_old;
  assign any_edge  = s_now ^ s_old;
  assign evt_pulse = mode_in & ch_en & (both_sel ? any_edge : rise);
endmodule

module tmr_chan_pol_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_in,
  input logic [1:0] prot_lvl,
  input logic       wr_en,
  input logic [3:0] rd_data,
  input logic       out_main,
  input logic       out_comp,
  input logic       evt_pulse
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> (rd_data == 4'b0000));

  // R8
  pol_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot_lvl[1]) |=> (rd_data[1] == $past(rd_data[1]) && rd_data[3] == $past(rd_data[3])));

  // R4
  main_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[0] || mode_in) |-> !out_main);

  // R4
  comp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[2] || mode_in) |-> !out_comp);

  // R7
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (mode_in && rd_data[0]));
endmodule

bind tmr_chan_pol tmr_chan_pol_chk u_chk (.*);

// File: tb/tmr_chan_pol_bench.sv
module tmr_chan_pol_bench;
  logic clk = 0;
  logic rst_n = 0, mode = 0, refw = 0, sig = 0, wr = 0;
  logic [1:0] prot = 0;
  logic [3:0] wd = 0;
  logic [3:0] rd;
  logic om, oc, ev;

  int n_cmp = 0, n_bad = 0;
  bit m_en, m_pm, m_ce, m_pc, m_d1, m_d2, blocked;
  bit live = 0;

  always #5 clk = ~clk;

  tmr_chan_pol u_tmr_chan_pol (
    .clk(clk), .rst_n(rst_n), .mode_in(mode), .ref_in(refw), .sig_in(sig),
    .prot_lvl(prot), .wr_en(wr), .wr_data(wd), .rd_data(rd),
    .out_main(om), .out_comp(oc), .evt_pulse(ev));

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pm = 0; m_ce = 0; m_pc = 0; m_d1 = 0; m_d2 = 0; blocked = 0;
    end else begin
      bit c;
      c = sig ^ (m_pm && !m_pc);
      m_d2 = m_d1;
      m_d1 = c;
      if (wr) begin
        m_en = wd[0];
        m_ce = wd[2];
        blocked = (prot >= 2);
        if (prot < 2) begin
          m_pm = wd[1];
          m_pc = wd[3];
        end
      end else blocked = 0;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      bit e_m, e_c, e_v;
      string tv;
      e_m = (!mode && m_en) ? (refw ^ m_pm) : 1'b0;
      e_c = (!mode && m_ce) ? (!refw ^ m_pc) : 1'b0;
      if (mode && m_en) begin
        if (m_pm && m_pc) e_v = (m_d1 != m_d2);
        else e_v = (m_d1 && !m_d2);
      end else e_v = 0;
      if (!(mode && m_en)) tv = "R7";
      else if (m_pc && !m_pm) tv = "R6";
      else tv = "R5";
      chk((!mode && m_en) ? "R2" : "R4", {3'b0, om}, {3'b0, e_m});
      chk((!mode && m_ce) ? "R3" : "R4", {3'b0, oc}, {3'b0, e_c});
      chk(tv, {3'b0, ev}, {3'b0, e_v});
      chk(blocked ? "R8" : "R9", rd, {m_pc, m_ce, m_pm, m_en});
    end
  end

  task automatic step(logic md, logic r, logic s, logic [1:0] p, logic w, logic [3:0] d);
    @(posedge clk);
    #2;
    mode = md; refw = r; sig = s; prot = p; wr = w; wd = d;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [3:0] sel [4];
    sel[0] = 4'b0001; sel[1] = 4'b0011; sel[2] = 4'b1011; sel[3] = 4'b1001;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rd, 4'b0000);
    chk("R1", {1'b0, om, oc, ev}, 4'b0000);
    live = 1;

    // output mode, free writes
    for (int i = 0; i < 400; i++)
      step(0, $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 4) == 0, $urandom % 16);

    // lock levels mixed with writes
    for (int i = 0; i < 400; i++)
      step($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4, ($urandom % 3) == 0, $urandom % 16);

    // input mode, each edge selection, slow toggles
    for (int k = 0; k < 4; k++) begin
      step(1, 0, sig, 0, 1, sel[k]);
      for (int i = 0; i < 150; i++)
        step(1, 0, (($urandom % 3) == 0) ? !sig : sig, 3, 0, 0);
    end

    // input mode, fast toggles, coinciding writes and locks
    for (int i = 0; i < 800; i++)
      step(1, $urandom % 2, $urandom % 2, $urandom % 4, ($urandom % 4) == 0, $urandom % 16);

    // R7 channel disabled in input mode
    step(1, 0, 0, 0, 1, 4'b0000);
    for (int i = 0; i < 40; i++) step(1, 0, i % 2, 0, 0, 0);

    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule